// File: doc/BRIEF.md
# Indirect and Direct Host Register Window

This block is the host-facing access unit of a network controller whose control registers and frame buffers share one 4 KB internal space. After reset the host reaches that space indirectly, through eight 16-bit I/O ports. It loads an internal address into a pointer port and then moves words through one of two data ports. Shortcut ports reach a few fixed registers without touching the pointer. Two frame data ports stream words: reads walk the current receive frame and writes fill the transmit area.

A control word in the bus-interface region can enable a second path. With that path enabled, host memory strobes that fall inside a 4 KB host window reach every internal word directly. The window's base is given by `win_base`. The internal space is held in a single-port block RAM inside the block. One word, the access-mode register, is kept in flip-flops so that reset can clear it.

Top module: `hwin_port`

## Requirements
- R1: After reset `host_rvalid` and `host_rdata` are 0, the pointer reads back as 0, and the access-mode register reads back as 0.
- R2: A write to I/O offset 0Ah loads the pointer with data bits 11:1. Bit 0 becomes 0 and bits 15:12 are dropped. A read of 0Ah returns the pointer, with bits 15:12 equal to 0.
- R3: I/O offset 0Ch reads and writes the internal word at the pointer. Offset 0Eh reads and writes the word at pointer+2, wrapping modulo 4 KB.
- R4: A read strobe accepted at one rising edge gives `host_rvalid` high for one cycle, with valid `host_rdata`, after the second rising edge that follows. Nothing is returned one cycle after the strobe.
- R5: Offsets 04h and 06h are the same storage as internal words 0144h and 0146h, for both reads and writes.
- R6: Offset 08h reads and writes internal word 0120h, the event queue word.
- R7: Reads at offset 00h or 02h return words 0400h, 0402h, 0404h, and so on, stepping once per read. A pulse on `rx_new` restarts the walk at 0400h.
- R8: Writes at offset 00h or 02h store to 0A00h, 0A02h, and so on, stepping once per write. Any write to internal word 0144h, through 04h or through the pointer, restarts the walk at 0A00h.
- R9: Bit 0 of internal word 0016h enables direct access. Reset clears the whole word to 0, and the word reads back as written.
- R10: With direct access enabled, a memory strobe whose `mem_addr[19:12]` equals `win_base` reaches internal word `mem_addr[11:1]`. A memory strobe outside the window does nothing.
- R11: With direct access disabled, memory strobes change no word and return no data.
- R12: The following are ignored: I/O strobes at odd offsets, memory strobes at odd addresses, and cycles with both read and write strobes of the same path high. A memory strobe in the same cycle as an I/O strobe is also dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_rd | input | 1 | I/O read strobe |
| io_wr | input | 1 | I/O write strobe |
| io_ofs | input | 4 | I/O port byte offset |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| mem_addr | input | 20 | Host memory address |
| win_base | input | 8 | Host address bits 19:12 of the direct window |
| host_wdata | input | 16 | Write data for either path |
| rx_new | input | 1 | Pulse when a new receive frame is presented |
| host_rdata | output | 16 | Read data, held between reads |
| host_rvalid | output | 1 | One-cycle marker that `host_rdata` carries a new result |

## Verification
The internal space is first filled through the pointer with a word pattern, so every later read can be compared against a known value. Directed cases cover the points where paths are easy to confuse:
- a pointer loaded with high and odd bits, and the pointer+2 port at the top of the space, which tell masking and wrap faults apart;
- shortcut ports and pointer accesses to the same word, which show whether aliases share storage;
- frame port walks across a new-frame pulse and a command write, which separate the two index restarts;
- memory strobes inside and outside the window, with direct access on and off, which separate window decode from mode gating.

Random mixes of all port kinds, with seeded pointer values and data, then catch interactions between the shortcut writes, the pointer writes and the frame walks.

// File: rtl/hwin_pkg.sv
package hwin_pkg;
  // internal word addresses with fixed meaning (12-bit space)
  localparam logic [11:0] RX_AREA   = 12'h400;
  localparam logic [11:0] TX_AREA   = 12'hA00;
  localparam logic [11:0] TXCMD_ADR = 12'h144;
  localparam logic [11:0] TXLEN_ADR = 12'h146;
  localparam logic [11:0] EVQ_ADR   = 12'h120;
  localparam logic [11:0] MODE_ADR  = 12'h016;

  // I/O port index = offset bits 3:1
  typedef enum logic [2:0] {
    PORT_FRM0 = 3'd0,
    PORT_FRM1 = 3'd1,
    PORT_TCMD = 3'd2,
    PORT_TLEN = 3'd3,
    PORT_EVQ  = 3'd4,
    PORT_PTR  = 3'd5,
    PORT_DAT0 = 3'd6,
    PORT_DAT1 = 3'd7
  } port_t;
endpackage

// File: rtl/hwin_decode.sv
module hwin_decode
  import hwin_pkg::*;
#(
  parameter int IA_W = 12,
  parameter int HA_W = 20
) (
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [3:0]           io_ofs,
  input  logic                 mem_rd,
  input  logic                 mem_wr,
  input  logic [HA_W-1:0]      mem_addr,
  input  logic [HA_W-IA_W-1:0] win_base,
  input  logic                 direct_en,
  input  logic [IA_W-1:0]      ptr,
  input  logic [IA_W-1:0]      rx_off,
  input  logic [IA_W-1:0]      tx_off,
  output logic                 acc_en,
  output logic                 acc_we,
  output logic [IA_W-1:0]      acc_addr,
  output logic                 ptr_we,
  output logic                 ptr_rd,
  output logic                 rx_step,
  output logic                 tx_step
);
  logic  io_ok, mem_ok;
  port_t port;

  always_comb begin
    port     = port_t'(io_ofs[3:1]);
    io_ok    = (io_rd ^ io_wr) && !io_ofs[0];
    mem_ok   = direct_en && (mem_rd ^ mem_wr) && !mem_addr[0] &&
               (mem_addr[HA_W-1:IA_W] == win_base) && !(io_rd || io_wr);
    acc_en   = 1'b0;
    acc_we   = 1'b0;
    acc_addr = '0;
    ptr_we   = 1'b0;
    ptr_rd   = 1'b0;
    rx_step  = 1'b0;
    tx_step  = 1'b0;
    if (io_ok) begin
      acc_en = (port != PORT_PTR);
      acc_we = io_wr;
      unique case (port)
        PORT_FRM0, PORT_FRM1: begin
          acc_addr = io_wr ? IA_W'(TX_AREA) + tx_off : IA_W'(RX_AREA) + rx_off;
          rx_step  = io_rd;
          tx_step  = io_wr;
        end
        PORT_TCMD: acc_addr = IA_W'(TXCMD_ADR);
        PORT_TLEN: acc_addr = IA_W'(TXLEN_ADR);
        PORT_EVQ:  acc_addr = IA_W'(EVQ_ADR);
        PORT_PTR: begin
          ptr_we = io_wr;
          ptr_rd = io_rd;
        end
        PORT_DAT0: acc_addr = ptr;
        PORT_DAT1: acc_addr = ptr + IA_W'(2);
        default:   acc_addr = '0;
      endcase
    end else if (mem_ok) begin
      acc_en   = 1'b1;
      acc_we   = mem_wr;
      acc_addr = {mem_addr[IA_W-1:1], 1'b0};
    end
  end
endmodule

// File: rtl/hwin_store.sv
module hwin_store #(
  parameter int DW = 16,
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/hwin_port.sv
module hwin_port
  import hwin_pkg::*;
#(
  parameter int DW   = 16,
  parameter int IA_W = 12,
  parameter int HA_W = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_rd,
  input  logic                 io_wr,
  input  logic [3:0]           io_ofs,
  input  logic                 mem_rd,
  input  logic                 mem_wr,
  input  logic [HA_W-1:0]      mem_addr,
  input  logic [HA_W-IA_W-1:0] win_base,
  input  logic [DW-1:0]        host_wdata,
  input  logic                 rx_new,
  output logic [DW-1:0]        host_rdata,
  output logic                 host_rvalid
);
  localparam int IDX_W = IA_W - 1;
  localparam int WA_W  = IA_W - 1;

  logic [IA_W-1:0]  ptr_q;
  logic [DW-1:0]    mode_q;
  logic [IDX_W-1:0] rx_idx, tx_idx;
  logic             acc_en, acc_we, ptr_we, ptr_rd, rx_step, tx_step;
  logic [IA_W-1:0]  acc_addr;
  logic             store_we, tx_clr, mode_hit;
  logic [DW-1:0]    ram_q;
  logic             rd1_q, hold_sel_q;
  logic [DW-1:0]    hold_q;

  hwin_decode #(.IA_W(IA_W), .HA_W(HA_W)) u_dec (
    .io_rd    (io_rd),
    .io_wr    (io_wr),
    .io_ofs   (io_ofs),
    .mem_rd   (mem_rd),
    .mem_wr   (mem_wr),
    .mem_addr (mem_addr),
    .win_base (win_base),
    .direct_en(mode_q[0]),
    .ptr      (ptr_q),
    .rx_off   ({rx_idx, 1'b0}),
    .tx_off   ({tx_idx, 1'b0}),
    .acc_en   (acc_en),
    .acc_we   (acc_we),
    .acc_addr (acc_addr),
    .ptr_we   (ptr_we),
    .ptr_rd   (ptr_rd),
    .rx_step  (rx_step),
    .tx_step  (tx_step)
  );

  assign store_we = acc_en && acc_we;
  assign mode_hit = acc_en && (acc_addr == IA_W'(MODE_ADR));
  assign tx_clr   = store_we && (acc_addr == IA_W'(TXCMD_ADR));

  hwin_store #(.DW(DW), .AW(WA_W)) u_ram (
    .clk  (clk),
    .en   (acc_en),
    .we   (store_we),
    .addr (acc_addr[IA_W-1:1]),
    .wdata(host_wdata),
    .rdata(ram_q)
  );

  // pointer, mode word and frame walk indexes
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      mode_q <= '0;
      rx_idx <= '0;
      tx_idx <= '0;
    end else begin
      if (ptr_we) ptr_q <= {host_wdata[IA_W-1:1], 1'b0};
      if (mode_hit && acc_we) mode_q <= host_wdata;
      if (rx_new) rx_idx <= '0;
      else if (rx_step) rx_idx <= rx_idx + IDX_W'(1);
      if (tx_clr) tx_idx <= '0;
      else if (tx_step) tx_idx <= tx_idx + IDX_W'(1);
    end
  end

  // two-stage read return
  always_ff @(posedge clk) begin
    if (rst) begin
      rd1_q       <= 1'b0;
      hold_sel_q  <= 1'b0;
      hold_q      <= '0;
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      rd1_q       <= (acc_en && !acc_we) || ptr_rd;
      hold_sel_q  <= ptr_rd || mode_hit;
      hold_q      <= ptr_rd ? {{(DW-IA_W){1'b0}}, ptr_q} : mode_q;
      host_rvalid <= rd1_q;
      if (rd1_q) host_rdata <= hold_sel_q ? hold_q : ram_q;
    end
  end
endmodule

// File: rtl/hwin_checks.sv
module hwin_checks #(
  parameter int DW   = 16,
  parameter int IA_W = 12
) (
  input logic            clk,
  input logic            rst,
  input logic            io_rd,
  input logic            io_wr,
  input logic [3:0]      io_ofs,
  input logic            mem_rd,
  input logic [DW-1:0]   host_wdata,
  input logic            host_rvalid,
  input logic            rx_new,
  input logic [IA_W-1:0] ptr_q,
  input logic [DW-1:0]   mode_q,
  input logic [IA_W-2:0] rx_idx,
  input logic [IA_W-2:0] tx_idx,
  input logic            store_we
);
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_rd && io_ofs == 4'hA) |=> ptr_q == {$past(host_wdata[IA_W-1:1]), 1'b0}); // R2
  AST_RD_RETURN: assert property (@(posedge clk) disable iff (rst)
    (io_rd && !io_wr && !io_ofs[0]) |=> ##1 host_rvalid); // R4
  AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    host_rvalid |-> $past(io_rd || mem_rd, 2)); // R4
  AST_MODE_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> mode_q == '0); // R9
  AST_MEM_GATED: assert property (@(posedge clk) disable iff (rst)
    (!mode_q[0] && !io_rd && !io_wr) |-> !store_we); // R11
  AST_RX_RESTART: assert property (@(posedge clk) disable iff (rst)
    rx_new |=> rx_idx == '0); // R7
  AST_TX_RESTART: assert property (@(posedge clk) disable iff (rst)
    (io_wr && !io_rd && io_ofs == 4'h4) |=> tx_idx == '0); // R8
endmodule

bind hwin_port hwin_checks #(.DW(DW), .IA_W(IA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .io_rd      (io_rd),
  .io_wr      (io_wr),
  .io_ofs     (io_ofs),
  .mem_rd     (mem_rd),
  .host_wdata (host_wdata),
  .host_rvalid(host_rvalid),
  .rx_new     (rx_new),
  .ptr_q      (ptr_q),
  .mode_q     (mode_q),
  .rx_idx     (rx_idx),
  .tx_idx     (tx_idx),
  .store_we   (store_we)
);

// File: tb/hwin_port_test.sv
`timescale 1ns/1ps
module hwin_port_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_rd = 0, io_wr = 0, mem_rd = 0, mem_wr = 0, rx_new = 0;
  logic [3:0]  io_ofs = 0;
  logic [19:0] mem_addr = 0;
  logic [7:0]  win_base = 8'hD4;
  logic [15:0] host_wdata = 0;
  logic [15:0] host_rdata;
  logic        host_rvalid;

  always #2.5 clk = ~clk;

  hwin_port uut (.*);

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] model [0:2047];
  logic [15:0] m_mode = 0;
  logic [11:0] m_ptr = 0;
  int m_rx = 0, m_tx = 0;

  function automatic logic [15:0] model_rd(logic [11:0] a);
    return (a == 12'h016) ? m_mode : model[a[11:1]];
  endfunction

  task automatic model_wr(logic [11:0] a, logic [15:0] d);
    model[a[11:1]] = d;
    if (a == 12'h016) m_mode = d;
    if (a == 12'h144) m_tx = 0;
  endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(bit ir, bit iw, bit mr, bit mw, logic [3:0] ofs,
                       logic [19:0] ma, logic [15:0] d);
    @(negedge clk);
    io_rd = ir; io_wr = iw; mem_rd = mr; mem_wr = mw;
    io_ofs = ofs; mem_addr = ma; host_wdata = d;
    @(negedge clk);
    io_rd = 0; io_wr = 0; mem_rd = 0; mem_wr = 0;
  endtask

  function automatic logic [11:0] port_addr(logic [3:0] ofs, bit wr);
    case (ofs[3:1])
      3'd0, 3'd1: return wr ? 12'hA00 + 12'(2*m_tx) : 12'h400 + 12'(2*m_rx);
      3'd2: return 12'h144;
      3'd3: return 12'h146;
      3'd4: return 12'h120;
      3'd6: return m_ptr;
      3'd7: return m_ptr + 12'd2;
      default: return 12'h000;
    endcase
  endfunction

  task automatic io_write(logic [3:0] ofs, logic [15:0] d);
    logic [11:0] a = port_addr(ofs, 1);
    if (!ofs[0]) begin
      if (ofs[3:1] == 3'd5) m_ptr = {d[11:1], 1'b0};
      else begin
        if (ofs[3:1] <= 3'd1) m_tx++;
        model_wr(a, d);
      end
    end
    drive(0, 1, 0, 0, ofs, 0, d);
  endtask

  task automatic io_read(logic [3:0] ofs, string req);
    logic [15:0] exp;
    logic [11:0] a = port_addr(ofs, 0);
    if (ofs[3:1] == 3'd5) exp = {4'h0, m_ptr};
    else exp = model_rd(a);
    if (ofs[3:1] <= 3'd1) m_rx++;
    drive(1, 0, 0, 0, ofs, 0, 0);
    chk({req, " R4 early"}, {15'd0, host_rvalid}, 16'd0);
    @(negedge clk);
    chk({req, " R4 valid"}, {15'd0, host_rvalid}, 16'd1);
    chk(req, host_rdata, exp);
  endtask

  function automatic bit in_win(logic [19:0] ma);
    return m_mode[0] && ma[19:12] == win_base && !ma[0];
  endfunction

  task automatic mem_write(logic [19:0] ma, logic [15:0] d);
    if (in_win(ma)) model_wr({ma[11:1], 1'b0}, d);
    drive(0, 0, 0, 1, 0, ma, d);
  endtask

  task automatic mem_read(logic [19:0] ma, string req);
    bit hit = in_win(ma);
    logic [15:0] exp = model_rd({ma[11:1], 1'b0});
    drive(0, 0, 1, 0, 0, ma, 0);
    @(negedge clk);
    chk({req, " rvalid"}, {15'd0, host_rvalid}, {15'd0, hit});
    if (hit) chk(req, host_rdata, exp);
  endtask

  task automatic ptr_write(logic [11:0] a, logic [15:0] d);
    io_write(4'hA, {4'h0, a});
    io_write(4'hC, d);
  endtask

  task automatic ptr_read(logic [11:0] a, string req);
    io_write(4'hA, {4'h0, a});
    io_read(4'hC, req);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_ptr = 0; m_mode = 0; m_rx = 0; m_tx = 0;
  endtask

  task automatic frame_pulse();
    @(negedge clk); rx_new = 1;
    @(negedge clk); rx_new = 0;
    m_rx = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED1234);
    do_reset();
    // R1 reset state
    chk("R1 rdata", host_rdata, 16'h0000);
    chk("R1 rvalid", {15'd0, host_rvalid}, 16'd0);
    io_read(4'hA, "R1 pointer");
    // fill the space with a known pattern
    for (int i = 0; i < 2048; i++) ptr_write(12'(2*i), 16'(i * 16'h9E37) ^ 16'h5A5A);
    ptr_write(12'h016, 16'h0000);
    do_reset();
    ptr_read(12'h016, "R1 R9 mode after reset");

    // R2 pointer masking
    io_write(4'hA, 16'hF7A3);
    io_read(4'hA, "R2 pointer mask");
    // R3 data ports and wrap
    io_write(4'hC, 16'hBEEF);
    io_read(4'hC, "R3 port0");
    io_read(4'hE, "R3 port1");
    io_write(4'hA, 16'h0FFE);
    io_write(4'hE, 16'h1357);
    ptr_read(12'h000, "R3 wrap");
    // R5 shortcut aliases
    io_write(4'h4, 16'hC0DE);
    ptr_read(12'h144, "R5 txcmd alias");
    ptr_write(12'h146, 16'h05EA);
    io_read(4'h6, "R5 txlen alias");
    // R6 event queue word
    ptr_write(12'h120, 16'h8421);
    io_read(4'h8, "R6 queue");
    // R7 receive walk
    frame_pulse();
    io_read(4'h0, "R7 rx word0");
    io_read(4'h2, "R7 rx word1");
    io_read(4'h0, "R7 rx word2");
    frame_pulse();
    io_read(4'h2, "R7 rx restart");
    // R8 transmit walk
    io_write(4'h4, 16'h0001);
    io_write(4'h0, 16'hA001);
    io_write(4'h2, 16'hA002);
    io_write(4'h0, 16'hA003);
    ptr_read(12'hA00, "R8 tx0");
    ptr_read(12'hA04, "R8 tx2");
    ptr_write(12'h144, 16'h0002);
    io_write(4'h2, 16'hB00B);
    ptr_read(12'hA00, "R8 restart by pointer");
    // R11 direct disabled
    mem_write({8'hD4, 12'h200}, 16'hDEAD);
    ptr_read(12'h200, "R11 mem write ignored");
    mem_read({8'hD4, 12'h200}, "R11 mem read ignored");
    // R9 / R10 direct enabled
    ptr_write(12'h016, 16'h0001);
    ptr_read(12'h016, "R9 mode readback");
    mem_write({8'hD4, 12'h202}, 16'h7777);
    ptr_read(12'h202, "R10 mem write in window");
    mem_read({8'hD4, 12'h146}, "R10 mem read");
    mem_write({8'hD5, 12'h204}, 16'h6666);
    ptr_read(12'h204, "R10 outside window");
    mem_read({8'hD3, 12'h204}, "R10 read outside window");
    // R12 ignored strobes
    io_write(4'hB, 16'h0FF0);
    io_read(4'hA, "R12 odd offset");
    mem_write({8'hD4, 12'h207}, 16'h1111);
    ptr_read(12'h206, "R12 odd address");
    drive(0, 1, 0, 1, 4'hC, {8'hD4, 12'h208}, 16'h2222);
    model_wr(m_ptr, 16'h2222);
    ptr_read(12'h208, "R12 io over mem");

    // random mix
    for (int n = 0; n < 700; n++) begin
      int op = $urandom_range(0, 9);
      logic [15:0] d = 16'($urandom);
      logic [11:0] a = 12'($urandom) & 12'h7FE;
      case (op)
        0: io_write(4'hA, d);
        1: io_write($urandom_range(0, 1) ? 4'hC : 4'hE, d);
        2: io_read($urandom_range(0, 1) ? 4'hC : 4'hE, "R3 random");
        3: io_write(4'(2 * $urandom_range(2, 4)), d);
        4: io_read(4'(2 * $urandom_range(2, 4)), "R5 R6 random");
        5: io_read($urandom_range(0, 1) ? 4'h0 : 4'h2, "R7 random");
        6: io_write($urandom_range(0, 1) ? 4'h0 : 4'h2, d);
        7: mem_write({($urandom_range(0, 3) != 0) ? win_base : 8'h11, a}, d);
        8: mem_read({($urandom_range(0, 3) != 0) ? win_base : 8'h11, a}, "R10 random");
        default: if ($urandom_range(0, 4) == 0) frame_pulse();
                 else ptr_write(12'h016, {15'd0, 1'($urandom)});
      endcase
    end

    do_reset();
    io_read(4'hA, "R1 pointer second reset");
    ptr_read(12'h016, "R9 mode second reset");
    io_read(4'h0, "R7 rx after reset");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule